// File: doc/BRIEF.md
# PHY Management Access Engine

This block lets a host reach the registers of an Ethernet PHY through the two-wire management interface. The host sees a small bank of byte-wide registers. It selects which PHY register to touch, then starts the transfer. Writing the upper data byte starts a write. Setting a read flag in the command register starts a read. The engine then clocks a complete management frame out on MDC and MDIO, and shows a busy flag for the whole transfer. When a read ends, the 16 returned bits sit in two result bytes.

The frame is 32 preamble ones followed by a 32-bit frame. The frame carries the start code, the opcode, a fixed PHY address, the register number, two turnaround bits and 16 data bits, sent MSB first. MDC is the system clock divided by a parameter. With the default divider at 125 MHz, one transfer lasts 10.24 us. The read flag is not cleared by the engine; the host clears it once it has collected the result. Any host write that arrives during a transfer is dropped.

Host register offsets: 0 register select (bits 4:0), 1 command (bit 0 = read), 2 status (bit 0 = busy), 3 write data low, 4 write data high, 5 read result low, 6 read result high. Offset 7 is unused.

Top module: `mii_mgmt_engine`

## Requirements
- R1: After reset all host registers read 0, MDC is low and MDIO is not driven.
- R2: Writing offset 4 while idle launches a write frame. The frame is 32 ones, then 01, opcode 01, the 5-bit PHY address, the 5-bit register select value, turnaround 10, and the data: high byte from the offset-4 write, low byte from offset 3. Every bit is sent MSB first. MDIO is driven for all 64 bits. Bits change only after MDC falls, so each bit is stable while MDC is high.
- R3: Writing offset 1 with bit 0 set while idle launches a read frame. It sends the same 46 leading bits, with opcode 10. MDIO is released from the first turnaround bit to the end of the frame.
- R4: During a read, MDIO is sampled on the rising MDC edge of each of the 16 data bits, MSB first. At the end of the frame the result is placed at offset 5 (bits 7:0) and offset 6 (bits 15:8).
- R5: Status bit 0 reads 1 from the clock after the launching write for exactly 128 x HALF_DIV clocks, then reads 0.
- R6: While busy, host writes to every offset are ignored, and none of them starts another transfer.
- R7: A write to offset 3 alone, or a write of 0 to offset 1, starts no transfer.
- R8: Command bit 0 stays 1 after a read completes, until the host writes it. A lingering read flag does not start another transfer.
- R9: MDC is low whenever the engine is idle. During a transfer it has a period of 2 x HALF_DIV clocks, giving 64 rising edges per transfer.
- R10: Offset 7 reads 0. Writes to offsets 5, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Host register offset |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data returned by the PHY |

## Verification
The bench sweeps every register number through both a write and a read, using computed data patterns including all-zero and all-one words. It captures each bit on the rising MDC edge and compares it with a frame assembled arithmetically.

- **Turnaround boundary.** An engine that released MDIO one bit late or one bit early would show up at bit 45 or bit 46 of the read frame.
- **Sampling phase.** An engine that sampled on the wrong edge would return a result shifted by one bit.
- **Busy length.** Busy is counted clock by clock, so an off-by-one bit counter changes the count.
- **Writes while busy.** The bench changes the register select, command and data registers mid-transfer, then reads them back. A design that let such a write through, or that relaunched from the lingering read flag, shows a changed value or extra MDC edges.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

  localparam int HOST_AW = 3;

  // host register offsets
  localparam logic [HOST_AW-1:0] OFS_REGSEL = 3'd0;
  localparam logic [HOST_AW-1:0] OFS_CMD    = 3'd1;
  localparam logic [HOST_AW-1:0] OFS_STAT   = 3'd2;
  localparam logic [HOST_AW-1:0] OFS_WDLO   = 3'd3;
  localparam logic [HOST_AW-1:0] OFS_WDHI   = 3'd4;
  localparam logic [HOST_AW-1:0] OFS_RDLO   = 3'd5;
  localparam logic [HOST_AW-1:0] OFS_RDHI   = 3'd6;

  // frame fields
  localparam logic [1:0] FLD_SOF   = 2'b01;
  localparam logic [1:0] FLD_OP_RD = 2'b10;
  localparam logic [1:0] FLD_OP_WR = 2'b01;
  localparam logic [1:0] FLD_TA_WR = 2'b10;
  localparam logic [1:0] FLD_TA_RD = 2'b11;

  // bit positions within one 64-bit transfer
  localparam logic [5:0] IDX_HDR  = 6'd32;  // first bit after preamble
  localparam logic [5:0] IDX_TA   = 6'd46;  // first turnaround bit
  localparam logic [5:0] IDX_DATA = 6'd48;  // first data bit
  localparam logic [5:0] IDX_LAST = 6'd63;

  typedef struct packed {
    logic        rd;
    logic [4:0]  reg_addr;
    logic [15:0] wdata;
  } mgmt_req_t;

endpackage

// File: rtl/mgmt_rst_sync.sv
module mgmt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int HALF_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          edge_hit;

  assign edge_hit = run && (cnt_q == CNT_TOP);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (start) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (run) begin
      if (edge_hit) begin
        cnt_d = '0;
        mdc_d = ~mdc_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = edge_hit && !mdc_q && !start;
  assign fall_stb = edge_hit &&  mdc_q && !start;

endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mii_mgmt_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  mgmt_req_t   req,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        mdio_i,
  output logic        start,
  output logic        busy,
  output logic        done_rd,
  output logic [15:0] rd_result,
  output logic        mdio_o,
  output logic        mdio_oe
);

  logic        busy_q, busy_d;
  logic [5:0]  idx_q, idx_d;
  logic [31:0] sh_q, sh_d;
  logic        rdm_q, rdm_d;
  logic [15:0] rsh_q, rsh_d;
  logic [31:0] hdr;
  logic        last_fall;

  assign start = launch && !busy_q;

  assign hdr = {FLD_SOF,
                req.rd ? FLD_OP_RD : FLD_OP_WR,
                PHY_ADDR,
                req.reg_addr,
                req.rd ? FLD_TA_RD : FLD_TA_WR,
                req.rd ? 16'h0000 : req.wdata};

  assign last_fall = busy_q && fall_stb && (idx_q == IDX_LAST);

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    rdm_d  = rdm_q;
    rsh_d  = rsh_q;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
      sh_d   = hdr;
      rdm_d  = req.rd;
    end else if (busy_q) begin
      if (rise_stb && rdm_q && (idx_q >= IDX_DATA)) begin
        rsh_d = {rsh_q[14:0], mdio_i};
      end
      if (fall_stb) begin
        if (idx_q == IDX_LAST) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          if (idx_q >= IDX_HDR) begin
            sh_d = {sh_q[30:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      rdm_q  <= 1'b0;
      rsh_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      rdm_q  <= rdm_d;
      rsh_q  <= rsh_d;
    end
  end

  assign busy      = busy_q;
  assign done_rd   = last_fall && rdm_q;
  assign rd_result = rsh_q;
  assign mdio_oe   = busy_q && !(rdm_q && (idx_q >= IDX_TA));
  assign mdio_o    = busy_q && ((idx_q < IDX_HDR) ? 1'b1 : sh_q[31]);

endmodule

// File: rtl/mgmt_host_regs.sv
module mgmt_host_regs
  import mii_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_we,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  input  logic               busy,
  input  logic               done_rd,
  input  logic [15:0]        rd_result,
  output logic               launch,
  output mgmt_req_t          req,
  output logic [4:0]         regsel,
  output logic               cmd_rd
);

  logic [4:0] regsel_q, regsel_d;
  logic       cmd_q, cmd_d;
  logic [7:0] wdlo_q, wdlo_d;
  logic [7:0] wdhi_q, wdhi_d;
  logic [7:0] rdlo_q, rdlo_d;
  logic [7:0] rdhi_q, rdhi_d;
  logic       wr_ok;
  logic       go_wr, go_rd;

  assign wr_ok = host_we && !busy;
  assign go_wr = wr_ok && (host_addr == OFS_WDHI);
  assign go_rd = wr_ok && (host_addr == OFS_CMD) && host_wdata[0];

  always_comb begin
    regsel_d = regsel_q;
    cmd_d    = cmd_q;
    wdlo_d   = wdlo_q;
    wdhi_d   = wdhi_q;
    rdlo_d   = rdlo_q;
    rdhi_d   = rdhi_q;
    if (wr_ok) begin
      case (host_addr)
        OFS_REGSEL: regsel_d = host_wdata[4:0];
        OFS_CMD:    cmd_d    = host_wdata[0];
        OFS_WDLO:   wdlo_d   = host_wdata;
        OFS_WDHI:   wdhi_d   = host_wdata;
        default:    ;
      endcase
    end
    if (done_rd) begin
      rdlo_d = rd_result[7:0];
      rdhi_d = rd_result[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regsel_q <= '0;
      cmd_q    <= 1'b0;
      wdlo_q   <= '0;
      wdhi_q   <= '0;
      rdlo_q   <= '0;
      rdhi_q   <= '0;
    end else begin
      regsel_q <= regsel_d;
      cmd_q    <= cmd_d;
      wdlo_q   <= wdlo_d;
      wdhi_q   <= wdhi_d;
      rdlo_q   <= rdlo_d;
      rdhi_q   <= rdhi_d;
    end
  end

  always_comb begin
    case (host_addr)
      OFS_REGSEL: host_rdata = {3'b000, regsel_q};
      OFS_CMD:    host_rdata = {7'b0, cmd_q};
      OFS_STAT:   host_rdata = {7'b0, busy};
      OFS_WDLO:   host_rdata = wdlo_q;
      OFS_WDHI:   host_rdata = wdhi_q;
      OFS_RDLO:   host_rdata = rdlo_q;
      OFS_RDHI:   host_rdata = rdhi_q;
      default:    host_rdata = 8'h00;
    endcase
  end

  assign launch       = go_wr || go_rd;
  assign req.rd       = go_rd;
  assign req.reg_addr = regsel_q;
  assign req.wdata    = {host_wdata, wdlo_q};
  assign regsel       = regsel_q;
  assign cmd_rd       = cmd_q;

endmodule

// File: rtl/mii_mgmt_engine.sv
module mii_mgmt_engine
  import mii_mgmt_pkg::*;
#(
  parameter int         HALF_DIV = 10,
  parameter logic [4:0] PHY_ADDR = 5'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_we,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);

  logic        rst_sync_n;
  logic        launch;
  mgmt_req_t   req;
  logic        start;
  logic        busy;
  logic        done_rd;
  logic [15:0] rd_result;
  logic        rise_stb, fall_stb;
  logic [4:0]  regsel;
  logic        cmd_rd;

  mgmt_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  mgmt_host_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_addr  (host_addr),
    .host_we    (host_we),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .busy       (busy),
    .done_rd    (done_rd),
    .rd_result  (rd_result),
    .launch     (launch),
    .req        (req),
    .regsel     (regsel),
    .cmd_rd     (cmd_rd)
  );

  mgmt_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .run      (busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mgmt_frame_engine #(.PHY_ADDR(PHY_ADDR)) u_frame (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .launch    (launch),
    .req       (req),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .mdio_i    (mdio_i),
    .start     (start),
    .busy      (busy),
    .done_rd   (done_rd),
    .rd_result (rd_result),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

endmodule

// File: rtl/mii_mgmt_checker.sv
module mii_mgmt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       host_we,
  input logic [4:0] regsel,
  input logic       cmd_rd
);

  // R9: clock parked low when idle
  assert_mdc_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R1: bus released when idle
  assert_mdio_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  // R2: data and enable hold while MDC is high
  assert_mdio_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R7: a transfer only begins after a host write
  assert_launch_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(host_we));

  // R6: register select frozen during a transfer
  assert_regsel_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(regsel));

  // R8: read flag changes only by host write
  assert_cmd_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !host_we |=> $stable(cmd_rd));

endmodule

bind mii_mgmt_engine mii_mgmt_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .busy    (busy),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .host_we (host_we),
  .regsel  (regsel),
  .cmd_rd  (cmd_rd)
);

// File: tb/test_mii_mgmt_engine.sv
module test_mii_mgmt_engine;

  localparam int         HALF = 2;
  localparam logic [4:0] PHY  = 5'h0A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       we = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic       mdc, mdio_o, mdio_oe;
  logic       mdio_i;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  mii_mgmt_engine #(.HALF_DIV(HALF), .PHY_ADDR(PHY)) i_mii_mgmt_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (addr),
    .host_we    (we),
    .host_wdata (wd),
    .host_rdata (rd),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .mdio_i     (mdio_i)
  );

  // bus monitor and PHY responder
  logic [63:0] cap_o, cap_oe;
  int          nrise = 0;
  int          per_bad = 0;
  int          glitch = 0;
  int          since = 0;
  logic        mdc_p = 1'b0;
  logic        o_p = 1'b0;
  logic [15:0] pat = 16'h0000;

  always @(negedge clk) begin
    if (mdc && !mdc_p) begin
      if (nrise < 64) begin
        cap_o[63-nrise]  = mdio_o;
        cap_oe[63-nrise] = mdio_oe;
      end
      if (nrise > 0 && since != 2*HALF) per_bad++;
      nrise++;
      since = 0;
    end
    since++;
    if (mdc && mdc_p && (mdio_o !== o_p)) glitch++;
    mdc_p = mdc;
    o_p   = mdio_o;
    mdio_i = (nrise >= 48 && nrise < 64) ? pat[63-nrise] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wd = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rd;
  endtask

  task automatic wait_idle(output int cyc);
    addr = 3'd2;
    cyc = 0;
    #1;
    while (rd[0] && cyc < 20000) begin
      cyc++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic clear_cap();
    nrise = 0; per_bad = 0; glitch = 0; cap_o = '0; cap_oe = '0;
  endtask

  function automatic logic [63:0] exp_frame(input bit rdop, input logic [4:0] r,
                                            input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rdop ? 2'b10 : 2'b01), PHY, r,
            (rdop ? 2'b00 : 2'b10), (rdop ? 16'h0000 : d)};
  endfunction

  localparam logic [63:0] RD_OE_MASK = {{46{1'b1}}, {18{1'b0}}};

  task automatic do_write(input logic [4:0] r, input logic [15:0] d);
    int c;
    host_wr(3'd0, {3'b000, r});
    host_wr(3'd3, d[7:0]);
    clear_cap();
    host_wr(3'd4, d[15:8]);
    wait_idle(c);
    chk(c == 128*HALF, "R5", "write busy cycles", 64'(c), 64'(128*HALF));
    chk(nrise == 64 && per_bad == 0, "R9", "write MDC edges", 64'(nrise), 64'd64);
    chk(glitch == 0, "R2", "write MDIO change while MDC high", 64'(glitch), 64'd0);
    chk(cap_o == exp_frame(1'b0, r, d), "R2", "write frame", cap_o, exp_frame(1'b0, r, d));
    chk(cap_oe == '1, "R2", "write drive enable", cap_oe, '1);
  endtask

  task automatic do_read(input logic [4:0] r, input logic [15:0] p);
    int c;
    logic [7:0] v;
    logic [63:0] e;
    pat = p;
    host_wr(3'd0, {3'b000, r});
    clear_cap();
    host_wr(3'd1, 8'h01);
    wait_idle(c);
    e = exp_frame(1'b1, r, 16'h0);
    chk(c == 128*HALF, "R5", "read busy cycles", 64'(c), 64'(128*HALF));
    chk((cap_o & RD_OE_MASK) == (e & RD_OE_MASK), "R3", "read frame head",
        cap_o & RD_OE_MASK, e & RD_OE_MASK);
    chk(cap_oe == RD_OE_MASK, "R3", "read release", cap_oe, RD_OE_MASK);
    host_rd(3'd5, v);
    chk(v == p[7:0], "R4", "result low", 64'(v), 64'(p[7:0]));
    host_rd(3'd6, v);
    chk(v == p[15:8], "R4", "result high", 64'(v), 64'(p[15:8]));
    host_rd(3'd1, v);
    chk(v == 8'h01, "R8", "read flag kept", 64'(v), 64'h1);
    repeat (40) @(negedge clk);
    host_rd(3'd2, v);
    chk(nrise == 64 && v == 8'h00, "R8", "no relaunch from flag", 64'(nrise), 64'd64);
    host_wr(3'd1, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      host_rd(3'(a), v);
      chk(v == 8'h00, "R1", "reset register", 64'(v), 64'h0);
    end
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "idle pins", {62'b0, mdc, mdio_oe}, 64'h0);

    // R7 no launch from low-byte write or command clear
    clear_cap();
    host_wr(3'd3, 8'h99);
    host_wr(3'd1, 8'h00);
    host_wr(3'd1, 8'hFE);
    repeat (20) @(negedge clk);
    host_rd(3'd2, v);
    chk(nrise == 0 && v == 8'h00, "R7", "no spurious launch", 64'(nrise), 64'd0);

    // R10 unused offset and read-only results
    host_wr(3'd7, 8'h55);
    host_wr(3'd5, 8'h77);
    host_wr(3'd6, 8'h77);
    host_rd(3'd7, v);
    chk(v == 8'h00, "R10", "unused offset", 64'(v), 64'h0);
    host_rd(3'd5, v);
    chk(v == 8'h00, "R10", "result low read-only", 64'(v), 64'h0);
    host_rd(3'd6, v);
    chk(v == 8'h00 && nrise == 0, "R10", "result high read-only", 64'(v), 64'h0);

    // sweeps over all register numbers
    do_write(5'd0, 16'h0000);
    do_write(5'd31, 16'hFFFF);
    for (int r = 0; r < 32; r++) begin
      do_write(5'(r), 16'hA5C3 ^ 16'(r * 16'h0841));
    end
    do_read(5'd0, 16'h0000);
    do_read(5'd31, 16'hFFFF);
    for (int r = 0; r < 32; r++) begin
      do_read(5'(r), 16'h1E69 ^ 16'(r * 16'h3107));
    end

    // R6 writes during a transfer
    host_wr(3'd0, 8'h03);
    host_wr(3'd3, 8'h3C);
    clear_cap();
    host_wr(3'd4, 8'h5A);
    host_wr(3'd0, 8'h1F);
    host_wr(3'd1, 8'h01);
    host_wr(3'd4, 8'hFF);
    host_wr(3'd3, 8'h11);
    wait_idle(c);
    repeat (40) @(negedge clk);
    chk(nrise == 64, "R6", "no extra transfer", 64'(nrise), 64'd64);
    chk(cap_o == exp_frame(1'b0, 5'd3, 16'h5A3C), "R6", "frame unaffected",
        cap_o, exp_frame(1'b0, 5'd3, 16'h5A3C));
    host_rd(3'd0, v);
    chk(v == 8'h03, "R6", "register select kept", 64'(v), 64'h03);
    host_rd(3'd1, v);
    chk(v == 8'h00, "R6", "command kept", 64'(v), 64'h00);
    host_rd(3'd4, v);
    chk(v == 8'h5A, "R6", "data high kept", 64'(v), 64'h5A);
    host_rd(3'd3, v);
    chk(v == 8'h3C, "R6", "data low kept", 64'(v), 64'h3C);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R9", "idle after transfer",
        {62'b0, mdc, mdio_oe}, 64'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule